// File: doc/BRIEF.md
# Repeated Block Copy Sequencer

This block runs a counted memory-to-memory copy for a 16-bit segmented address space. A single start pulse loads the element count, the source and destination offsets, the segment values, the element size (byte or word) and the direction of travel. The sequencer then moves one element per iteration. It reads it through a request/acknowledge memory port, writes it back at the destination, and then updates the count and both offsets. When the count reaches zero it raises a one-cycle completion pulse.

Every physical address is 20 bits wide. It is the segment value times sixteen plus the 16-bit offset. The source segment is the data segment input, unless the caller asks for a substitute segment. The destination always takes the extra segment input, even when a substitute is requested. The final count and both offsets stay on output ports after completion, so the surrounding core can write them back to its registers.

Top module: `strmove_seq`

## Requirements
- R1: While reset (active-low, synchronous) is applied and on the first cycle after it, `busy`, `done` and `mem_req` are 0.
- R2: A read request carries address (S*16 + SI) mod 2^20, where S is `ovr_seg` when `ovr_en` is 1 at start and `ds_seg` otherwise, and SI is the current source offset.
- R3: A write request carries address (`es_seg`*16 + DI) mod 2^20 for every value of `ovr_en` and `ovr_seg`, where DI is the current destination offset.
- R4: Each iteration is one read request (`mem_we`=0) followed by one write request (`mem_we`=1). Each request holds `mem_req`, `mem_addr` and `mem_we` steady until a cycle with `mem_ack`=1. The write data equals the `mem_rdata` captured at the read acknowledge.
- R5: After each element, both offsets move by 1 when `word_mode`=0 and by 2 when `word_mode`=1.
- R6: With `dir_down`=0 the offsets increase, and with `dir_down`=1 they decrease.
- R7: The count decreases by one at each write acknowledge. Exactly `init_count` elements are moved, and no further request follows the one that brings the count to zero.
- R8: A start with `init_count`=0 issues no memory request and raises `done` in the cycle after the start edge.
- R9: Offsets wrap modulo 2^16 and physical addresses wrap modulo 2^20.
- R10: `done` is high for exactly one cycle. A `start` seen while `busy`=1 changes neither the count, the offsets nor the memory traffic.
- R11: When `done` is high, and afterwards until the next accepted start, `cnt_out`, `si_out` and `di_out` show the final count and offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a copy (taken only when idle) |
| init_count | input | 16 | Number of elements to move |
| ds_seg | input | 16 | Default source segment |
| es_seg | input | 16 | Destination segment |
| ovr_en | input | 1 | Use `ovr_seg` for the source |
| ovr_seg | input | 16 | Substitute source segment |
| src_off | input | 16 | Initial source offset |
| dst_off | input | 16 | Initial destination offset |
| word_mode | input | 1 | 1 = 16-bit elements, 0 = bytes |
| dir_down | input | 1 | 1 = offsets decrement |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_word | output | 1 | Element size of the request |
| mem_addr | output | 20 | Physical address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completed this cycle |
| busy | output | 1 | Copy in progress or completing |
| done | output | 1 | One-cycle completion pulse |
| cnt_out | output | 16 | Current/final count |
| si_out | output | 16 | Current/final source offset |
| di_out | output | 16 | Current/final destination offset |

## Verification
The assertions assume three things about the memory side. `mem_ack` is raised only while `mem_req` is high, it lasts one cycle per request, and `mem_rdata` is valid in that cycle. Under those assumptions the stability and count-step properties hold. The bench meets them by driving a one-cycle acknowledge only after it has seen a request, and it waits a set number of cycles first. It lowers the acknowledge on the next falling edge, and it drives `start` only on falling edges, including the stray start pulses it sends mid-copy.

// File: rtl/strmove_pkg.sv
// Shared types for the block copy sequencer.
// Assumes nothing beyond a two-bit state encoding.
package strmove_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_FIN   = 2'd3
    } seq_state_t;
endpackage

// File: rtl/strmove_phys.sv
// Forms a physical address from a segment and an offset: the segment is
// shifted left by SEG_SHIFT and the zero-extended offset is added; the
// carry out of the top bit is dropped (wrap modulo 2^PA_W).
module strmove_phys #(
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int PA_W     = OFF_W + SEG_SHIFT
) (
    input  logic [OFF_W-1:0] seg,
    input  logic [OFF_W-1:0] off,
    output logic [PA_W-1:0]  phys
);
    // Combine shifted segment with offset; truncation gives the wrap.
    always_comb begin
        phys = {seg, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off};
    end
endmodule

// File: rtl/strmove_step.sv
// Computes the next offset after one element: stride 1 for bytes and 2 for
// words, added or subtracted per the direction bit, modulo 2^OFF_W.
module strmove_step #(
    parameter int OFF_W = 16
) (
    input  logic [OFF_W-1:0] off,
    input  logic             word,
    input  logic             down,
    output logic [OFF_W-1:0] nxt
);
    localparam logic [OFF_W-1:0] ONE = OFF_W'(1);

    logic [OFF_W-1:0] stride;

    // Pick the element stride, then move in the chosen direction.
    always_comb begin
        stride = word ? (ONE << 1) : ONE;
        nxt    = down ? (off - stride) : (off + stride);
    end
endmodule

// File: rtl/strmove_ctrl.sv
// Phase controller: idle -> read -> write (repeat) -> finish -> idle.
// Assumes mem_ack is only meaningful while a phase is requesting, and that
// cnt_last reflects whether the element being written is the final one.
module strmove_ctrl
    import strmove_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       init_zero,
    input  logic       cnt_last,
    input  logic       mem_ack,
    output seq_state_t st
);
    seq_state_t st_nx;

    // Next-state selection for the copy phases.
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (start) st_nx = init_zero ? ST_FIN : ST_READ;
            ST_READ:  if (mem_ack) st_nx = ST_WRITE;
            ST_WRITE: if (mem_ack) st_nx = cnt_last ? ST_FIN : ST_READ;
            ST_FIN:   st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // R10
    fin_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FIN) |=> (st == ST_IDLE));

    // R4
    read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ && mem_ack) |=> (st == ST_WRITE));
endmodule

// File: rtl/strmove_seq.sv
// Block copy sequencer top. Loads the copy setup on an idle start, then
// alternates read and write requests, stepping count and offsets after
// every write acknowledge. Assumes a one-cycle mem_ack per request with
// mem_rdata valid alongside the read acknowledge.
module strmove_seq
    import strmove_pkg::*;
#(
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int CNT_W     = 16,
    parameter int DATA_W    = 16,
    localparam int PA_W     = OFF_W + SEG_SHIFT,
    localparam int N_CH     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  init_count,
    input  logic [OFF_W-1:0]  ds_seg,
    input  logic [OFF_W-1:0]  es_seg,
    input  logic              ovr_en,
    input  logic [OFF_W-1:0]  ovr_seg,
    input  logic [OFF_W-1:0]  src_off,
    input  logic [OFF_W-1:0]  dst_off,
    input  logic              word_mode,
    input  logic              dir_down,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [PA_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  cnt_out,
    output logic [OFF_W-1:0]  si_out,
    output logic [OFF_W-1:0]  di_out
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    seq_state_t        st;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] data_q;
    logic              word_q;
    logic              down_q;
    logic [OFF_W-1:0]  seg_q  [N_CH];
    logic [OFF_W-1:0]  off_q  [N_CH];
    logic [OFF_W-1:0]  off_nx [N_CH];
    logic [PA_W-1:0]   phys   [N_CH];
    logic              accept;
    logic              wr_done;

    assign accept  = (st == ST_IDLE) && start;
    assign wr_done = (st == ST_WRITE) && mem_ack;

    strmove_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .init_zero (init_count == '0),
        .cnt_last  (cnt_q == CNT_ONE),
        .mem_ack   (mem_ack),
        .st        (st)
    );

    // Channel 0 is the source, channel 1 the destination.
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        strmove_phys #(.OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT)) u_phys (
            .seg  (seg_q[c]),
            .off  (off_q[c]),
            .phys (phys[c])
        );
        strmove_step #(.OFF_W(OFF_W)) u_step (
            .off  (off_q[c]),
            .word (word_q),
            .down (down_q),
            .nxt  (off_nx[c])
        );
    end

    // Setup capture on accept; source segment honours the substitute,
    // destination segment never does.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q[0] <= '0;
            seg_q[1] <= '0;
            word_q   <= 1'b0;
            down_q   <= 1'b0;
        end else if (accept) begin
            seg_q[0] <= ovr_en ? ovr_seg : ds_seg;
            seg_q[1] <= es_seg;
            word_q   <= word_mode;
            down_q   <= dir_down;
        end
    end

    // Count and offsets: load on accept, step after each write acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            off_q[0] <= '0;
            off_q[1] <= '0;
        end else if (accept) begin
            cnt_q    <= init_count;
            off_q[0] <= src_off;
            off_q[1] <= dst_off;
        end else if (wr_done) begin
            cnt_q    <= cnt_q - CNT_ONE;
            off_q[0] <= off_nx[0];
            off_q[1] <= off_nx[1];
        end
    end

    // Hold the element read for the following write phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                         data_q <= '0;
        else if (st == ST_READ && mem_ack)  data_q <= mem_rdata;
    end

    // Memory port and status outputs decoded from the phase.
    always_comb begin
        mem_req   = (st == ST_READ) || (st == ST_WRITE);
        mem_we    = (st == ST_WRITE);
        mem_word  = word_q;
        mem_addr  = (st == ST_WRITE) ? phys[1] : phys[0];
        mem_wdata = data_q;
        busy      = (st != ST_IDLE);
        done      = (st == ST_FIN);
        cnt_out   = cnt_q;
        si_out    = off_q[0];
        di_out    = off_q[1];
    end

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R7
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (cnt_out == $past(cnt_out) - CNT_ONE));

    // R5 R6
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=>
            ((si_out - $past(si_out)) == (di_out - $past(di_out))) &&
            ($countones(si_out ^ $past(si_out)) != 0));

    // R8
    zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && init_count == '0) |=> (done && !mem_req));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(mem_req && mem_we && mem_ack)) |=>
            ($stable(cnt_out) && $stable(si_out) && $stable(di_out)));

    // R3
    dst_seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(seg_q[1]));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !mem_req));
endmodule

// File: tb/strmove_seq_tb_top.sv
// Directed bench: each task runs one copy scenario against a bench-side
// memory responder and checks addresses, data, steps and completion.
module strmove_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] init_count, ds_seg, es_seg, ovr_seg, src_off, dst_off;
    logic        ovr_en, word_mode, dir_down;
    logic        mem_req, mem_we, mem_word, mem_ack;
    logic [19:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        busy, done;
    logic [15:0] cnt_out, si_out, di_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    strmove_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .init_count(init_count),
        .ds_seg(ds_seg), .es_seg(es_seg), .ovr_en(ovr_en), .ovr_seg(ovr_seg),
        .src_off(src_off), .dst_off(dst_off), .word_mode(word_mode),
        .dir_down(dir_down), .mem_req(mem_req), .mem_we(mem_we),
        .mem_word(mem_word), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .busy(busy), .done(done),
        .cnt_out(cnt_out), .si_out(si_out), .di_out(di_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] pa(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    function automatic logic [15:0] data_at(input logic [19:0] a);
        return a[15:0] ^ {a[19:16], 12'h5A3};
    endfunction

    task automatic wait_req();
        for (int i = 0; i < 60 && !mem_req; i++) @(negedge clk);
    endtask

    // One full copy; checks every request, both phases, steps and completion.
    task automatic run_copy(input logic [15:0] cnt, input logic [15:0] ds,
                            input logic [15:0] es, input logic oe,
                            input logic [15:0] os, input logic [15:0] si,
                            input logic [15:0] di, input logic wm,
                            input logic dn, input int lat, input bit poke,
                            input string tag);
        logic [15:0] e_si = si, e_di = di, stride, sseg;
        logic [19:0] ra, a0;
        stride = wm ? 16'd2 : 16'd1;
        sseg   = oe ? os : ds;
        @(negedge clk);
        init_count = cnt; ds_seg = ds; es_seg = es; ovr_en = oe; ovr_seg = os;
        src_off = si; dst_off = di; word_mode = wm; dir_down = dn; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // scramble setup inputs after accept: must not matter
        ds_seg = ~ds; es_seg = ~es; ovr_seg = ~os; src_off = 16'h1357;
        for (int k = 0; k < cnt; k++) begin
            wait_req();
            ra = pa(sseg, e_si);
            chk(mem_req && !mem_we, {"R4 read phase ", tag}, {mem_req, mem_we}, 2'b10);
            chk(mem_addr == ra, {"R2 source address ", tag}, mem_addr, ra);
            chk(mem_word == wm, {"R5 element size ", tag}, mem_word, wm);
            a0 = mem_addr;
            for (int w = 0; w < lat; w++) begin
                @(negedge clk);
                chk(mem_req && mem_addr == a0 && !mem_we, {"R4 read held ", tag}, mem_addr, a0);
            end
            mem_rdata = data_at(ra); mem_ack = 1'b1;
            if (poke && k == 0) begin start = 1'b1; init_count = 16'h0077; end
            @(negedge clk);
            mem_ack = 1'b0; start = 1'b0; mem_rdata = 16'hDEAD;
            chk(mem_req && mem_we, {"R4 write phase ", tag}, {mem_req, mem_we}, 2'b11);
            chk(mem_addr == pa(es, e_di), {"R3 destination address ", tag}, mem_addr, pa(es, e_di));
            chk(mem_wdata == data_at(ra), {"R4 write data ", tag}, mem_wdata, data_at(ra));
            chk(cnt_out == cnt - 16'(k), {"R10 count unaffected ", tag}, cnt_out, cnt - 16'(k));
            for (int w = 0; w < lat; w++) begin
                @(negedge clk);
                chk(mem_req && mem_we, {"R4 write held ", tag}, mem_req, 1);
            end
            mem_ack = 1'b1;
            @(negedge clk);
            mem_ack = 1'b0;
            e_si = dn ? e_si - stride : e_si + stride;
            e_di = dn ? e_di - stride : e_di + stride;
            chk(si_out == e_si && di_out == e_di, {"R5 R6 R9 offset step ", tag},
                {si_out, di_out}, {e_si, e_di});
        end
        chk(done && !mem_req, {"R7 finish after last element ", tag}, {done, mem_req}, 2'b10);
        chk(cnt_out == 16'd0 && si_out == e_si && di_out == e_di,
            {"R11 final values ", tag}, {si_out, di_out}, {e_si, e_di});
        @(negedge clk);
        chk(!done && !busy && !mem_req, {"R10 done single pulse ", tag}, {done, busy}, 0);
        chk(cnt_out == 16'd0 && si_out == e_si && di_out == e_di,
            {"R11 values held ", tag}, {si_out, di_out}, {e_si, e_di});
    endtask

    task automatic test_reset();
        rst_n = 1'b0; start = 1'b0; mem_ack = 1'b0; mem_rdata = '0;
        init_count = '0; ds_seg = '0; es_seg = '0; ovr_en = 1'b0; ovr_seg = '0;
        src_off = '0; dst_off = '0; word_mode = 1'b0; dir_down = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req, "R1 in reset", {busy, done, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_req, "R1 after reset", {busy, done, mem_req}, 0);
    endtask

    task automatic test_zero_count();
        @(negedge clk);
        init_count = 16'd0; src_off = 16'h0ABC; dst_off = 16'h0DEF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done && !mem_req, "R8 zero count done next cycle", {done, mem_req}, 2'b10);
        chk(si_out == 16'h0ABC && di_out == 16'h0DEF, "R8 R11 zero count offsets",
            {si_out, di_out}, {16'h0ABC, 16'h0DEF});
        @(negedge clk);
        chk(!done && !mem_req && !busy, "R8 R10 zero count back to idle", {done, busy}, 0);
    endtask

    initial begin
        #(20ns * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        run_copy(16'd3, 16'h1000, 16'h2000, 1'b0, 16'h3000, 16'h0010, 16'h0100,
                 1'b0, 1'b0, 0, 1'b0, "byte up");
        run_copy(16'd4, 16'h1000, 16'h2000, 1'b1, 16'h3000, 16'h0040, 16'h0200,
                 1'b1, 1'b1, 2, 1'b0, "word down override");
        run_copy(16'd2, 16'h4444, 16'h5555, 1'b1, 16'h0123, 16'h0000, 16'h0003,
                 1'b0, 1'b1, 1, 1'b0, "byte down override");
        test_zero_count();
        run_copy(16'd3, 16'hFFFF, 16'hFFFF, 1'b0, 16'h0000, 16'hFFFE, 16'h0002,
                 1'b1, 1'b0, 0, 1'b0, "R9 wrap word up");
        run_copy(16'd2, 16'h00F0, 16'hF000, 1'b0, 16'h0000, 16'h0000, 16'h0001,
                 1'b1, 1'b1, 1, 1'b0, "R9 wrap word down");
        run_copy(16'd2, 16'h0800, 16'h0900, 1'b0, 16'h0000, 16'h0020, 16'h0030,
                 1'b0, 1'b0, 1, 1'b1, "R10 start while busy");
        run_copy(16'd1, 16'h0001, 16'h0002, 1'b0, 16'h0000, 16'h0005, 16'h0006,
                 1'b1, 1'b0, 3, 1'b0, "R7 single element");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule